// File: doc/BRIEF.md
# Line Miss Tracker with Merging

This block keeps track of loads that missed in the level-one data cache while their lines are being fetched from the next cache level. Each slot is keyed by the real line address, which is the address with the 7 offset bits of a 128-byte line removed. A miss to a line that no slot tracks yet takes a free slot, and the next level is asked for that line. A later miss to a line that a slot already tracks joins that slot and sends no second request.

When the next level returns a line, every load waiting on it gets a wakeup with its tag and byte offset, and the slot is released in the same cycle. A miss that cannot be taken is rejected in the cycle it is presented so the load pipeline can replay it. A miss is rejected when the queue is full, when the slot holding its line is already full, or when its line is returning in that same cycle. Pending requests wait while the next level is not ready, and they leave one per cycle in allocation order.

Top module: `lmq_merge`

## Requirements
- R1: After reset no slot is in use: `full` is low, `refill_req_valid` is low and both `wake_valid` bits are low.
- R2: A miss to a line that no slot holds, presented while a slot is free, is not rejected, and the request for that line appears on `refill_req_valid`/`refill_req_line` in the next cycle.
- R3: Line matching uses only the line address. Two misses with the same line address and different byte offsets go to the same slot, and each keeps its own offset.
- R4: A second miss to a line that a slot already holds is not rejected, takes no new slot and causes no further refill request.
- R5: A third miss to a line whose slot already holds two loads is rejected, and the slot's contents stay unchanged.
- R6: `full` is high exactly when all 8 slots are in use. A miss to a new line is then rejected, no slot is taken and no request is made, while merging into a held line still works.
- R7: Pending requests stay on the request port, with a stable line, while `refill_req_ready` is low. They are issued one per accepted cycle, oldest allocation first, whatever slot each one occupies.
- R8: In the cycle a returned line matches a slot, `wake_valid[0]` carries the first load's tag and offset and `wake_valid[1]` carries the second load's, if there is one. The slot is freed at the next edge, so a repeat return of that line wakes nothing.
- R9: A returned line that matches no slot produces no wakeup and changes nothing.
- R10: A miss presented in the same cycle that its line is returning is rejected and is not added to the leaving slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | A load missed this cycle |
| alloc_line | input | LINE_W (35) | Real line address of the missing load |
| alloc_tag | input | TAG_W (6) | Load identifier |
| alloc_off | input | LINE_OFF_W (7) | Byte offset of the load inside the line |
| alloc_reject | output | 1 | The miss could not be taken and must be replayed |
| full | output | 1 | Every slot is in use |
| refill_req_valid | output | 1 | A line request is offered to the next level |
| refill_req_line | output | LINE_W (35) | Line requested |
| refill_req_ready | input | 1 | The next level takes the offered request this cycle |
| refill_ret_valid | input | 1 | A line has come back from the next level |
| refill_ret_line | input | LINE_W (35) | Line address that came back |
| wake_valid | output | 2 | Per-lane wakeup; lane 1 only with lane 0 |
| wake_tag | output | 2*TAG_W (12) | Lane 1 tag in the upper half, lane 0 in the lower |
| wake_off | output | 2*LINE_OFF_W (14) | Lane 1 offset in the upper half, lane 0 in the lower |

## Verification
The hardest case to reach is a request order that differs from slot order. With only one miss port and a ready next level, requests never pile up. The stimulus therefore holds `refill_req_ready` low while three misses allocate. It then returns the oldest line before its request is issued, which frees the lowest slot, and a fourth miss reuses that slot. When ready rises, the requests must come out in allocation order, with the youngest entry in the lowest slot issued last. A scoreboard queue holds the expected request lines, and a monitor compares them as they are accepted.

// File: rtl/lmq_pkg.sv
package lmq_pkg;

  // number of loads one slot can hold
  localparam int SLOTS_PER_LINE = 2;

  // what happens to the miss presented this cycle
  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,
    ACT_NEW    = 2'd1,
    ACT_MERGE  = 2'd2,
    ACT_REJECT = 2'd3
  } alloc_act_e;

endpackage

// File: rtl/lmq_cam.sv
module lmq_cam #(
  parameter int N  = 8,
  parameter int LW = 35
) (
  input  logic [N-1:0]         ent_valid,
  input  logic [N-1:0][LW-1:0] ent_line,
  input  logic [LW-1:0]        probe_a,
  input  logic [LW-1:0]        probe_b,
  output logic [N-1:0]         hit_a,
  output logic [N-1:0]         hit_b
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_a[g] = ent_valid[g] && (ent_line[g] == probe_a);
    assign hit_b[g] = ent_valid[g] && (ent_line[g] == probe_b);
  end

endmodule

// File: rtl/lmq_oldest.sv
module lmq_oldest #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_oh,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  // older_q[i][j] set: slot i was allocated before slot j
  logic [N-1:0][N-1:0] older_q;
  logic [N-1:0][N-1:0] older_d;
  logic                older_en;

  assign older_en = |alloc_oh;

  always_comb begin
    older_d = older_q;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (alloc_oh[i]) older_d[i][j] = 1'b0;
        if (alloc_oh[j] && (i != j)) older_d[i][j] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      older_q <= '0;
    end else if (older_en) begin
      older_q <= older_d;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (req[j] && older_q[j][i]) blocked = 1'b1;
      end
      grant[i] = req[i] && !blocked;
    end
  end

  assert_grant_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));

  assert_grant_present_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|grant));

endmodule

// File: rtl/lmq_merge.sv
module lmq_merge
  import lmq_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int RA_W       = 42,
  parameter int LINE_OFF_W = 7,
  parameter int TAG_W      = 6,
  localparam int LINE_W    = RA_W - LINE_OFF_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           alloc_valid,
  input  logic [LINE_W-1:0]              alloc_line,
  input  logic [TAG_W-1:0]               alloc_tag,
  input  logic [LINE_OFF_W-1:0]          alloc_off,
  output logic                           alloc_reject,
  output logic                           full,
  output logic                           refill_req_valid,
  output logic [LINE_W-1:0]              refill_req_line,
  input  logic                           refill_req_ready,
  input  logic                           refill_ret_valid,
  input  logic [LINE_W-1:0]              refill_ret_line,
  output logic [SLOTS_PER_LINE-1:0]      wake_valid,
  output logic [2*TAG_W-1:0]             wake_tag,
  output logic [2*LINE_OFF_W-1:0]        wake_off
);

  // slot state
  logic [ENTRIES-1:0]                  valid_q, valid_d;
  logic [ENTRIES-1:0]                  pend_q, pend_d;
  logic [ENTRIES-1:0]                  two_q, two_d;
  logic [ENTRIES-1:0][LINE_W-1:0]      line_q;
  logic [ENTRIES-1:0][TAG_W-1:0]       tag0_q, tag1_q;
  logic [ENTRIES-1:0][LINE_OFF_W-1:0]  off0_q, off1_q;

  logic [ENTRIES-1:0] hit_alloc, hit_ret;
  logic [ENTRIES-1:0] free_vec, new_oh, free_oh, merge_oh;
  logic [ENTRIES-1:0] grant, ret_free;
  logic               ret_same_line;
  alloc_act_e         act;

  lmq_cam #(.N(ENTRIES), .LW(LINE_W)) u_cam (
    .ent_valid (valid_q),
    .ent_line  (line_q),
    .probe_a   (alloc_line),
    .probe_b   (refill_ret_line),
    .hit_a     (hit_alloc),
    .hit_b     (hit_ret)
  );

  // lowest free slot, one-hot
  assign free_vec = ~valid_q;
  assign free_oh  = free_vec & (~free_vec + 1'b1);

  assign ret_same_line = refill_ret_valid && (refill_ret_line == alloc_line);

  always_comb begin
    act = ACT_IDLE;
    if (alloc_valid) begin
      if (ret_same_line)                    act = ACT_REJECT;
      else if (|hit_alloc)                  act = (|(hit_alloc & two_q)) ? ACT_REJECT : ACT_MERGE;
      else if (|free_vec)                   act = ACT_NEW;
      else                                  act = ACT_REJECT;
    end
  end

  assign alloc_reject = (act == ACT_REJECT);
  assign new_oh       = (act == ACT_NEW)   ? free_oh   : '0;
  assign merge_oh     = (act == ACT_MERGE) ? hit_alloc : '0;
  assign ret_free     = refill_ret_valid ? hit_ret : '0;
  assign full         = &valid_q;

  lmq_oldest #(.N(ENTRIES)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_oh (new_oh),
    .req      (valid_q & pend_q),
    .grant    (grant)
  );

  assign refill_req_valid = |grant;

  always_comb begin
    refill_req_line = '0;
    wake_tag        = '0;
    wake_off        = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      refill_req_line = refill_req_line | (line_q[i] & {LINE_W{grant[i]}});
      wake_tag[TAG_W-1:0]       = wake_tag[TAG_W-1:0] | (tag0_q[i] & {TAG_W{ret_free[i]}});
      wake_tag[2*TAG_W-1:TAG_W] = wake_tag[2*TAG_W-1:TAG_W] |
                                  (tag1_q[i] & {TAG_W{ret_free[i] & two_q[i]}});
      wake_off[LINE_OFF_W-1:0]  = wake_off[LINE_OFF_W-1:0] | (off0_q[i] & {LINE_OFF_W{ret_free[i]}});
      wake_off[2*LINE_OFF_W-1:LINE_OFF_W] = wake_off[2*LINE_OFF_W-1:LINE_OFF_W] |
                                  (off1_q[i] & {LINE_OFF_W{ret_free[i] & two_q[i]}});
    end
  end

  assign wake_valid[0] = |ret_free;
  assign wake_valid[1] = |(ret_free & two_q);

  // control next state
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      valid_d[i] = (valid_q[i] && !ret_free[i]) || new_oh[i];
      if (new_oh[i])                           pend_d[i] = 1'b1;
      else if (ret_free[i])                    pend_d[i] = 1'b0;
      else if (grant[i] && refill_req_ready)   pend_d[i] = 1'b0;
      else                                     pend_d[i] = pend_q[i];
      if (new_oh[i])                           two_d[i] = 1'b0;
      else if (merge_oh[i])                    two_d[i] = 1'b1;
      else                                     two_d[i] = two_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      pend_q  <= '0;
      two_q   <= '0;
    end else begin
      valid_q <= valid_d;
      pend_q  <= pend_d;
      two_q   <= two_d;
    end
  end

  // payload registers, written only when a slot is filled
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (new_oh[g]) begin
        line_q[g] <= alloc_line;
        tag0_q[g] <= alloc_tag;
        off0_q[g] <= alloc_off;
      end
    end
    always_ff @(posedge clk) begin
      if (merge_oh[g]) begin
        tag1_q[g] <= alloc_tag;
        off1_q[g] <= alloc_off;
      end
    end
  end

  // checks
  assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_alloc));

  assert_req_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_NEW) |=> refill_req_valid);

  assert_full_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && full && !(|hit_alloc)) |-> alloc_reject);

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req_valid && !refill_req_ready &&
     !(refill_ret_valid && (refill_ret_line == refill_req_line)))
    |=> (refill_req_valid && $stable(refill_req_line)));

  assert_wake_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid[1] |-> wake_valid[0]);

  assert_slot_freed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid[0] |=> !full);

  assert_same_line_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && refill_ret_valid && (alloc_line == refill_ret_line)) |-> alloc_reject);

endmodule

// File: tb/sim_lmq_merge.sv
module sim_lmq_merge;

  localparam int LW = 35;
  localparam int TW = 6;
  localparam int OW = 7;

  logic          clk;
  logic          rst_n;
  logic          alloc_valid;
  logic [LW-1:0] alloc_line;
  logic [TW-1:0] alloc_tag;
  logic [OW-1:0] alloc_off;
  logic          alloc_reject;
  logic          full;
  logic          refill_req_valid;
  logic [LW-1:0] refill_req_line;
  logic          refill_req_ready;
  logic          refill_ret_valid;
  logic [LW-1:0] refill_ret_line;
  logic [1:0]    wake_valid;
  logic [2*TW-1:0] wake_tag;
  logic [2*OW-1:0] wake_off;

  int checks;
  int errors;
  bit done;
  logic [LW-1:0] exp_q [$];

  lmq_merge u0 (
    .clk              (clk),
    .rst_n            (rst_n),
    .alloc_valid      (alloc_valid),
    .alloc_line       (alloc_line),
    .alloc_tag        (alloc_tag),
    .alloc_off        (alloc_off),
    .alloc_reject     (alloc_reject),
    .full             (full),
    .refill_req_valid (refill_req_valid),
    .refill_req_line  (refill_req_line),
    .refill_req_ready (refill_req_ready),
    .refill_ret_valid (refill_ret_valid),
    .refill_ret_line  (refill_ret_line),
    .wake_valid       (wake_valid),
    .wake_tag         (wake_tag),
    .wake_off         (wake_off)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus at the falling edge, settle, return
  task automatic cyc(input logic av, input logic [LW-1:0] al, input logic [TW-1:0] at,
                     input logic [OW-1:0] ao, input logic rv, input logic [LW-1:0] rl,
                     input logic rdy);
    @(negedge clk);
    alloc_valid      = av;
    alloc_line       = al;
    alloc_tag        = at;
    alloc_off        = ao;
    refill_ret_valid = rv;
    refill_ret_line  = rl;
    refill_req_ready = rdy;
    #1;
  endtask

  // new-line miss: expect acceptance and queue the request it must produce
  task automatic miss_new(input logic [LW-1:0] al, input logic [TW-1:0] at,
                          input logic [OW-1:0] ao, input logic rdy, input bit expect_req);
    cyc(1'b1, al, at, ao, 1'b0, '0, rdy);
    chk("R2 new miss accepted", 64'(alloc_reject), 64'd0);
    if (expect_req) exp_q.push_back(al);
  endtask

  task automatic idle(input logic rdy);
    cyc(1'b0, '0, '0, '0, 1'b0, '0, rdy);
  endtask

  // scoreboard monitor: compares every accepted request with the queue
  always @(negedge clk) begin
    #1;
    if (rst_n && refill_req_valid && refill_req_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4/R7 unexpected request act %h exp none", refill_req_line);
      end else begin
        logic [LW-1:0] e;
        e = exp_q.pop_front();
        if (refill_req_line !== e) begin
          errors++;
          $display("FAIL R7 request order act %h exp %h", refill_req_line, e);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    alloc_valid = 1'b0; alloc_line = '0; alloc_tag = '0; alloc_off = '0;
    refill_ret_valid = 1'b0; refill_ret_line = '0; refill_req_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 full after reset", 64'(full), 64'd0);
    chk("R1 no request after reset", 64'(refill_req_valid), 64'd0);
    chk("R1 no wake after reset", 64'(wake_valid), 64'd0);

    // merge and overflow of one slot
    miss_new(35'h100, 6'd1, 7'd5, 1'b1, 1'b1);
    cyc(1'b1, 35'h100, 6'd2, 7'd9, 1'b0, '0, 1'b1);
    chk("R4 merge accepted", 64'(alloc_reject), 64'd0);
    cyc(1'b1, 35'h100, 6'd3, 7'd1, 1'b0, '0, 1'b1);
    chk("R5 third load rejected", 64'(alloc_reject), 64'd1);
    idle(1'b1);
    cyc(1'b0, '0, '0, '0, 1'b1, 35'h100, 1'b1);
    chk("R8 both lanes wake", 64'(wake_valid), 64'd3);
    chk("R5 R8 wake tags", 64'(wake_tag), 64'({6'd2, 6'd1}));
    chk("R3 R8 wake offsets", 64'(wake_off), 64'({7'd9, 7'd5}));
    cyc(1'b0, '0, '0, '0, 1'b1, 35'h100, 1'b1);
    chk("R8 freed line wakes nothing", 64'(wake_valid), 64'd0);
    cyc(1'b0, '0, '0, '0, 1'b1, 35'h777, 1'b1);
    chk("R9 unknown line wakes nothing", 64'(wake_valid), 64'd0);

    // fill every slot
    for (int i = 0; i < 8; i++) begin
      chk("R6 not full before last slot", 64'(full), 64'd0);
      miss_new(35'h200 + LW'(i), TW'(10 + i), OW'(i), 1'b1, 1'b1);
    end
    idle(1'b1);
    chk("R6 full with eight slots", 64'(full), 64'd1);
    cyc(1'b1, 35'h300, 6'd40, 7'd0, 1'b0, '0, 1'b1);
    chk("R6 new line rejected when full", 64'(alloc_reject), 64'd1);
    cyc(1'b1, 35'h203, 6'd41, 7'd77, 1'b0, '0, 1'b1);
    chk("R6 merge allowed when full", 64'(alloc_reject), 64'd0);
    cyc(1'b0, '0, '0, '0, 1'b1, 35'h203, 1'b1);
    chk("R8 merged slot wakes two", 64'(wake_valid), 64'd3);
    chk("R8 merged slot tags", 64'(wake_tag), 64'({6'd41, 6'd13}));
    idle(1'b1);
    chk("R8 slot freed drops full", 64'(full), 64'd0);
    for (int i = 0; i < 8; i++) begin
      if (i != 3) begin
        cyc(1'b0, '0, '0, '0, 1'b1, 35'h200 + LW'(i), 1'b1);
        chk("R8 single lane wake", 64'(wake_valid), 64'd1);
        chk("R8 single lane tag", 64'(wake_tag[TW-1:0]), 64'(10 + i));
      end
    end

    // same-line race
    miss_new(35'h400, 6'd20, 7'd3, 1'b1, 1'b1);
    idle(1'b1);
    cyc(1'b1, 35'h400, 6'd21, 7'd4, 1'b1, 35'h400, 1'b1);
    chk("R10 same-cycle miss rejected", 64'(alloc_reject), 64'd1);
    chk("R10 only first lane wakes", 64'(wake_valid), 64'd1);
    cyc(1'b0, '0, '0, '0, 1'b1, 35'h400, 1'b1);
    chk("R10 no entry left behind", 64'(wake_valid), 64'd0);

    // backlog ordering with a reused low slot
    miss_new(35'h500, 6'd30, 7'd0, 1'b0, 1'b0);
    idle(1'b0);
    chk("R7 request offered", 64'(refill_req_valid), 64'd1);
    chk("R7 oldest line offered", 64'(refill_req_line), 64'h500);
    miss_new(35'h501, 6'd31, 7'd0, 1'b0, 1'b1);
    miss_new(35'h502, 6'd32, 7'd0, 1'b0, 1'b1);
    chk("R7 line held while not ready", 64'(refill_req_line), 64'h500);
    cyc(1'b0, '0, '0, '0, 1'b1, 35'h500, 1'b0);
    idle(1'b0);
    chk("R7 next oldest after free", 64'(refill_req_line), 64'h501);
    miss_new(35'h503, 6'd33, 7'd0, 1'b0, 1'b1);
    repeat (5) idle(1'b1);
    chk("R7 backlog drained", 64'(exp_q.size()), 64'd0);
    chk("R4 no stray request", 64'(refill_req_valid), 64'd0);
    for (int i = 1; i < 4; i++) begin
      cyc(1'b0, '0, '0, '0, 1'b1, 35'h500 + LW'(i), 1'b1);
      chk("R8 backlog slot wakes", 64'(wake_tag[TW-1:0]), 64'(30 + i));
    end
    idle(1'b1);
    chk("R1 empty at end", 64'(full | refill_req_valid), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule